// File: doc/BRIEF.md
# Store-to-Load Forwarding Lookup

This block decides, in one clock, what an executing load should do given the stores that sit ahead of it in the store queue and have not yet drained to memory. It reads a snapshot of every store queue slot (address, byte size, uncacheable flag, sequence number, data bytes). It walks the slots older than the load, youngest first, and classifies the load against each usable store as fully contained, partly overlapping or disjoint. The first store that touches the load decides the outcome. A containing store forwards its bytes. A partly overlapping store sends the load back for a later retry and arms a stall record. With no touching store the load goes to the cache, or it is marked blocked when the cache cannot accept it.

Before the walk, an uncacheable load is turned back with a fault unless it is the oldest load and is ready to commit. For cache accesses that were cut in two, a small per-load counter signals completion only when the last of the outstanding responses has come back. All outcomes appear on registered outputs one cycle after the request.

Top module: `slf_lookup`

## Requirements
- R1: The searched slots run from slot `ld_sq_idx-1` downward to slot `sq_wb_idx` inclusive, wrapping modulo SQ_DEPTH. When `ld_sq_idx == sq_wb_idx` no slot is searched. Slots outside that window never influence the result.
- R2: A slot whose size is 0 (address not yet known) or whose `sq_uncache` bit is 1 is passed over as if absent.
- R3: Among searched slots, the youngest one (nearest to `ld_sq_idx-1`) whose bytes intersect the load decides the outcome, and `rsp_src_idx` reports it.
- R4: Full containment holds when `ld_addr >= store addr` and `ld_addr+ld_size <= store addr+store size`. Then `rsp_fwd`=1 and byte j of `rsp_fwd_data` equals store byte `(ld_addr & (store size-1)) + j` for j < `ld_size`, and zero above. Byte 0 is bits [7:0].
- R5: An intersection without containment gives `rsp_partial`=1 and `rsp_resched`=1, with no forward and no memory request.
- R6: A partial outcome loads the stall record (`stall_store_seq` from the store, `stall_lq_idx` from the load) when the record is empty or the new `ld_seq` is strictly smaller than the recorded load's. Otherwise the record is unchanged. `stall_release` empties the record, and a partial outcome in the same cycle is applied after the release.
- R7: A load with `ld_uncache`=1 gives `rsp_fault`=1 and `rsp_resched`=1 without any search, unless `ld_lq_idx == lq_head` and `ld_at_commit`=1.
- R8: With no intersecting store and `cache_blocked`=0, `rsp_mem_req`=1 and `rsp_split` copies `ld_split`.
- R9: With no intersecting store and `cache_blocked`=1, `rsp_blocked`=1 and the blocked record takes `ld_seq`. The exception is an existing record with a strictly smaller sequence, which is kept. `blocked_clear` empties the record before any same-cycle update.
- R10: After a memory request, `load_done` pulses with `load_done_idx` for one cycle, one clock after the final response for that load arrives on `mem_rsp_*`. For a split request the final response is the second one; otherwise it is the first.
- R11: During and right after reset, `rsp_valid`, `stall_active`, `blocked_active` and `load_done` are 0.
- R12: Every request yields `rsp_valid`=1 exactly one clock later, together with `rsp_lq_idx`. Exactly one of `rsp_fwd`, `rsp_partial`, `rsp_mem_req`, `rsp_blocked`, `rsp_fault` is 1. With no request, all of them are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request present this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SIZE_W | Load byte count (1..DATA_BYTES) |
| ld_seq | input | SEQ_W | Load age, smaller is older |
| ld_lq_idx | input | LQ_IW | Load queue slot of the load |
| ld_sq_idx | input | SQ_IW | Store slot recorded when the load was dispatched |
| ld_uncache | input | 1 | Load targets uncacheable space |
| ld_at_commit | input | 1 | Load is ready to commit |
| ld_split | input | 1 | Cache access will be two requests |
| lq_head | input | LQ_IW | Oldest load queue slot |
| cache_blocked | input | 1 | Cache cannot accept a request |
| sq_wb_idx | input | SQ_IW | Oldest store not yet written back |
| sq_addr | input | SQ_DEPTH x ADDR_W | Store addresses |
| sq_size | input | SQ_DEPTH x SIZE_W | Store byte counts, 0 = unknown |
| sq_uncache | input | SQ_DEPTH | Store uncacheable flags |
| sq_seq | input | SQ_DEPTH x SEQ_W | Store sequence numbers |
| sq_data | input | SQ_DEPTH x 8*DATA_BYTES | Store data bytes |
| stall_release | input | 1 | Empty the stall record |
| blocked_clear | input | 1 | Empty the blocked record |
| mem_rsp_valid | input | 1 | Cache response arrives |
| mem_rsp_lq_idx | input | LQ_IW | Load slot of the response |
| rsp_valid | output | 1 | Outcome valid |
| rsp_lq_idx | output | LQ_IW | Load slot of the outcome |
| rsp_fwd | output | 1 | Data forwarded from a store |
| rsp_fwd_data | output | 8*DATA_BYTES | Forwarded bytes |
| rsp_src_idx | output | SQ_IW | Deciding store slot |
| rsp_partial | output | 1 | Partial overlap, retry later |
| rsp_mem_req | output | 1 | Send load to the cache |
| rsp_split | output | 1 | Cache access is split |
| rsp_blocked | output | 1 | Cache blocked, load marked |
| rsp_resched | output | 1 | Load must be reissued |
| rsp_fault | output | 1 | Uncacheable load rejected |
| stall_active | output | 1 | Stall record holds a load |
| stall_store_seq | output | SEQ_W | Store that caused the stall |
| stall_lq_idx | output | LQ_IW | Load held by the stall |
| blocked_active | output | 1 | Blocked record holds a load |
| blocked_seq | output | SEQ_W | Sequence of the blocked load |
| load_done | output | 1 | Load's cache access complete |
| load_done_idx | output | LQ_IW | Slot of the completed load |

## Verification
The checks take for granted that every store with a nonzero size is naturally aligned to a power-of-two size no larger than DATA_BYTES, that loads have a nonzero size, and that SQ_DEPTH is a power of two. They also assume a cache response only targets a load with a request outstanding, and never the slot being issued in the same cycle. The stimulus builds store tables from aligned power-of-two sizes, or size zero, over a small address range so that overlaps are frequent. It picks response slots from the reference model's own outstanding set and steers them away from the slot of any concurrent request.

// File: rtl/slf_pkg.sv
package slf_pkg;
  typedef enum logic [2:0] {
    OC_NONE  = 3'd0,
    OC_FWD   = 3'd1,
    OC_PART  = 3'd2,
    OC_MEM   = 3'd3,
    OC_BLOCK = 3'd4,
    OC_UCFLT = 3'd5
  } outcome_e;
endpackage

// File: rtl/slf_match.sv
module slf_match #(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SIZE_W-1:0] st_size,
  input  logic              st_uncache,
  output logic              full_hit,
  output logic              part_hit
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] ld_lo, ld_hi, st_lo, st_hi;
  logic          usable, touches, covers;

  always_comb begin
    ld_lo   = {1'b0, ld_addr};
    st_lo   = {1'b0, st_addr};
    ld_hi   = ld_lo + EW'(ld_size);
    st_hi   = st_lo + EW'(st_size);
    usable  = (st_size != '0) && !st_uncache;
    touches = (ld_lo < st_hi) && (ld_hi > st_lo);
    covers  = (ld_lo >= st_lo) && (ld_hi <= st_hi);
    full_hit = usable && covers;
    part_hit = usable && touches && !covers;
  end
endmodule

// File: rtl/slf_pick.sv
module slf_pick #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0]         full_vec,
  input  logic [DEPTH-1:0]         part_vec,
  input  logic [$clog2(DEPTH)-1:0] start_idx,
  input  logic [$clog2(DEPTH)-1:0] stop_idx,
  output logic                     sel_valid,
  output logic [$clog2(DEPTH)-1:0] sel_idx,
  output logic                     sel_full
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] span;
  logic [IW-1:0] ent;

  // Youngest-first walk: step k looks at slot start_idx-1-k.
  always_comb begin
    span      = start_idx - stop_idx;
    sel_valid = 1'b0;
    sel_idx   = '0;
    sel_full  = 1'b0;
    ent       = '0;
    for (int k = 0; k < DEPTH; k++) begin
      ent = start_idx - IW'(k + 1);
      if (!sel_valid && (k < int'(span)) && (full_vec[ent] || part_vec[ent])) begin
        sel_valid = 1'b1;
        sel_idx   = ent;
        sel_full  = full_vec[ent];
      end
    end
  end
endmodule

// File: rtl/slf_track.sv
module slf_track #(
  parameter int LQ_DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        issue,
  input  logic [$clog2(LQ_DEPTH)-1:0] issue_idx,
  input  logic                        issue_split,
  input  logic                        rsp_valid,
  input  logic [$clog2(LQ_DEPTH)-1:0] rsp_idx,
  output logic                        done,
  output logic [$clog2(LQ_DEPTH)-1:0] done_idx
);
  localparam int IW = $clog2(LQ_DEPTH);

  logic [LQ_DEPTH-1:0][1:0] cnt_q, cnt_d;
  logic                     done_d;
  logic [IW-1:0]            done_idx_d;

  always_comb begin
    cnt_d      = cnt_q;
    done_d     = 1'b0;
    done_idx_d = done_idx;
    if (rsp_valid && (cnt_q[rsp_idx] != 2'd0)) begin
      cnt_d[rsp_idx] = cnt_q[rsp_idx] - 2'd1;
      if (cnt_q[rsp_idx] == 2'd1) begin
        done_d     = 1'b1;
        done_idx_d = rsp_idx;
      end
    end
    if (issue) cnt_d[issue_idx] = issue_split ? 2'd2 : 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      done     <= 1'b0;
      done_idx <= '0;
    end else begin
      cnt_q <= cnt_d;
      done  <= done_d;
      if (done_d) done_idx <= done_idx_d;
    end
  end

  // R10: a completion only follows a response
  a_r10_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rsp_valid));
  // R10: a completion names the slot that responded
  a_r10_done_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_idx == $past(rsp_idx)));
endmodule

// File: rtl/slf_lookup.sv
module slf_lookup
  import slf_pkg::*;
#(
  parameter int SQ_DEPTH   = 8,
  parameter int LQ_DEPTH   = 8,
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 4,
  parameter int DATA_BYTES = 8,
  parameter int SEQ_W      = 8
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      ld_valid,
  input  logic [ADDR_W-1:0]                         ld_addr,
  input  logic [SIZE_W-1:0]                         ld_size,
  input  logic [SEQ_W-1:0]                          ld_seq,
  input  logic [$clog2(LQ_DEPTH)-1:0]               ld_lq_idx,
  input  logic [$clog2(SQ_DEPTH)-1:0]               ld_sq_idx,
  input  logic                                      ld_uncache,
  input  logic                                      ld_at_commit,
  input  logic                                      ld_split,
  input  logic [$clog2(LQ_DEPTH)-1:0]               lq_head,
  input  logic                                      cache_blocked,
  input  logic [$clog2(SQ_DEPTH)-1:0]               sq_wb_idx,
  input  logic [SQ_DEPTH-1:0][ADDR_W-1:0]           sq_addr,
  input  logic [SQ_DEPTH-1:0][SIZE_W-1:0]           sq_size,
  input  logic [SQ_DEPTH-1:0]                       sq_uncache,
  input  logic [SQ_DEPTH-1:0][SEQ_W-1:0]            sq_seq,
  input  logic [SQ_DEPTH-1:0][8*DATA_BYTES-1:0]     sq_data,
  input  logic                                      stall_release,
  input  logic                                      blocked_clear,
  input  logic                                      mem_rsp_valid,
  input  logic [$clog2(LQ_DEPTH)-1:0]               mem_rsp_lq_idx,
  output logic                                      rsp_valid,
  output logic [$clog2(LQ_DEPTH)-1:0]               rsp_lq_idx,
  output logic                                      rsp_fwd,
  output logic [8*DATA_BYTES-1:0]                   rsp_fwd_data,
  output logic [$clog2(SQ_DEPTH)-1:0]               rsp_src_idx,
  output logic                                      rsp_partial,
  output logic                                      rsp_mem_req,
  output logic                                      rsp_split,
  output logic                                      rsp_blocked,
  output logic                                      rsp_resched,
  output logic                                      rsp_fault,
  output logic                                      stall_active,
  output logic [SEQ_W-1:0]                          stall_store_seq,
  output logic [$clog2(LQ_DEPTH)-1:0]               stall_lq_idx,
  output logic                                      blocked_active,
  output logic [SEQ_W-1:0]                          blocked_seq,
  output logic                                      load_done,
  output logic [$clog2(LQ_DEPTH)-1:0]               load_done_idx
);
  localparam int SQ_IW = $clog2(SQ_DEPTH);
  localparam int LQ_IW = $clog2(LQ_DEPTH);
  localparam int DW    = 8 * DATA_BYTES;
  localparam int OFF_W = $clog2(DATA_BYTES);

  // ---------------- reset: async assert, sync release ----------------
  logic rst_m_n, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_s_n <= rst_m_n;
    end
  end

  // ---------------- per-slot classification ----------------
  logic [SQ_DEPTH-1:0] full_vec, part_vec;

  for (genvar e = 0; e < SQ_DEPTH; e++) begin : g_slot
    slf_match #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_match (
      .ld_addr    (ld_addr),
      .ld_size    (ld_size),
      .st_addr    (sq_addr[e]),
      .st_size    (sq_size[e]),
      .st_uncache (sq_uncache[e]),
      .full_hit   (full_vec[e]),
      .part_hit   (part_vec[e])
    );
  end

  logic             sel_valid, sel_full;
  logic [SQ_IW-1:0] sel_idx;

  slf_pick #(.DEPTH(SQ_DEPTH)) u_pick (
    .full_vec  (full_vec),
    .part_vec  (part_vec),
    .start_idx (ld_sq_idx),
    .stop_idx  (sq_wb_idx),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .sel_full  (sel_full)
  );

  // ---------------- byte extraction ----------------
  logic [SIZE_W-1:0] st_size_m1;
  logic [OFF_W-1:0]  fwd_off;
  logic [DW-1:0]     shifted;
  logic [DW-1:0]     fwd_bytes;

  always_comb begin
    st_size_m1 = sq_size[sel_idx] - SIZE_W'(1);
    fwd_off    = ld_addr[OFF_W-1:0] & st_size_m1[OFF_W-1:0];
    shifted    = sq_data[sel_idx] >> {fwd_off, 3'b000};
  end

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
    assign fwd_bytes[8*b +: 8] = (ld_size > SIZE_W'(b)) ? shifted[8*b +: 8] : 8'h00;
  end

  // ---------------- outcome decode ----------------
  outcome_e oc;
  logic     uc_reject;

  always_comb begin
    uc_reject = ld_uncache && !((ld_lq_idx == lq_head) && ld_at_commit);
    oc = OC_NONE;
    if (ld_valid) begin
      if (uc_reject)          oc = OC_UCFLT;
      else if (sel_valid)     oc = sel_full ? OC_FWD : OC_PART;
      else if (cache_blocked) oc = OC_BLOCK;
      else                    oc = OC_MEM;
    end
  end

  // ---------------- stall and blocked records: next state ----------------
  logic [SEQ_W-1:0] stall_lseq_q;
  logic             stall_base, stall_take, stall_active_d;
  logic             blk_base, blk_take, blocked_active_d;

  always_comb begin
    stall_base     = stall_active && !stall_release;
    stall_take     = (oc == OC_PART) && (!stall_base || (ld_seq < stall_lseq_q));
    stall_active_d = stall_base || stall_take;
    blk_base       = blocked_active && !blocked_clear;
    blk_take       = (oc == OC_BLOCK) && !(blk_base && (blocked_seq < ld_seq));
    blocked_active_d = blk_base || blk_take;
  end

  // ---------------- response registers ----------------
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rsp_valid    <= 1'b0;
      rsp_lq_idx   <= '0;
      rsp_fwd      <= 1'b0;
      rsp_fwd_data <= '0;
      rsp_src_idx  <= '0;
      rsp_partial  <= 1'b0;
      rsp_mem_req  <= 1'b0;
      rsp_split    <= 1'b0;
      rsp_blocked  <= 1'b0;
      rsp_resched  <= 1'b0;
      rsp_fault    <= 1'b0;
    end else begin
      rsp_valid    <= ld_valid;
      rsp_fwd      <= (oc == OC_FWD);
      rsp_fwd_data <= (oc == OC_FWD) ? fwd_bytes : '0;
      rsp_partial  <= (oc == OC_PART);
      rsp_mem_req  <= (oc == OC_MEM);
      rsp_split    <= (oc == OC_MEM) && ld_split;
      rsp_blocked  <= (oc == OC_BLOCK);
      rsp_resched  <= (oc == OC_PART) || (oc == OC_UCFLT);
      rsp_fault    <= (oc == OC_UCFLT);
      if (ld_valid) rsp_lq_idx <= ld_lq_idx;
      if ((oc == OC_FWD) || (oc == OC_PART)) rsp_src_idx <= sel_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      stall_active    <= 1'b0;
      stall_store_seq <= '0;
      stall_lq_idx    <= '0;
      stall_lseq_q    <= '0;
      blocked_active  <= 1'b0;
      blocked_seq     <= '0;
    end else begin
      stall_active   <= stall_active_d;
      blocked_active <= blocked_active_d;
      if (stall_take) begin
        stall_store_seq <= sq_seq[sel_idx];
        stall_lq_idx    <= ld_lq_idx;
        stall_lseq_q    <= ld_seq;
      end
      if (blk_take) blocked_seq <= ld_seq;
    end
  end

  // ---------------- split completion tracking ----------------
  slf_track #(.LQ_DEPTH(LQ_DEPTH)) u_track (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .issue       (oc == OC_MEM),
    .issue_idx   (ld_lq_idx),
    .issue_split (ld_split),
    .rsp_valid   (mem_rsp_valid),
    .rsp_idx     (mem_rsp_lq_idx),
    .done        (load_done),
    .done_idx    (load_done_idx)
  );

  // ---------------- assertions ----------------
  // R12: every request answered on the next clock
  a_r12_next_cycle: assert property (@(posedge clk) disable iff (!rst_s_n)
    ld_valid |=> rsp_valid);
  // R12: exactly one outcome flag per response
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_valid |-> ($countones({rsp_fwd, rsp_partial, rsp_mem_req, rsp_blocked, rsp_fault}) == 1));
  // R5: partial overlap reschedules and never reaches the cache
  a_r5_partial_resched: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_partial |-> (rsp_resched && !rsp_mem_req && !rsp_fwd));
  // R7: a rejected uncacheable load is always rescheduled
  a_r7_fault_resched: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsp_fault |-> rsp_resched);
  // R6: a held stall record is only replaced by an older load
  a_r6_stall_older: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stall_active && $past(stall_active) && !$past(stall_release)
     && (stall_lseq_q != $past(stall_lseq_q))) |-> (stall_lseq_q < $past(stall_lseq_q)));
  // R9: a held blocked record only moves to an older or equal load
  a_r9_blocked_older: assert property (@(posedge clk) disable iff (!rst_s_n)
    (blocked_active && $past(blocked_active) && !$past(blocked_clear)
     && (blocked_seq != $past(blocked_seq))) |-> (blocked_seq < $past(blocked_seq)));
  // R3: the chosen slot really intersects the load
  a_r3_pick_hits: assert property (@(posedge clk) disable iff (!rst_s_n)
    sel_valid |-> (full_vec[sel_idx] || part_vec[sel_idx]));
endmodule

// File: tb/test_slf_lookup.sv
`timescale 1ns/1ps
module test_slf_lookup;
  localparam int D   = 8;
  localparam int LQ  = 8;
  localparam int AW  = 16;
  localparam int SW  = 4;
  localparam int DB  = 8;
  localparam int QW  = 8;
  localparam int DW  = 8 * DB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic ld_valid, ld_uncache, ld_at_commit, ld_split, cache_blocked;
  logic [AW-1:0] ld_addr;
  logic [SW-1:0] ld_size;
  logic [QW-1:0] ld_seq;
  logic [2:0] ld_lq_idx, ld_sq_idx, lq_head, sq_wb_idx, mem_rsp_lq_idx;
  logic [D-1:0][AW-1:0] sq_addr;
  logic [D-1:0][SW-1:0] sq_size;
  logic [D-1:0]         sq_uncache;
  logic [D-1:0][QW-1:0] sq_seq;
  logic [D-1:0][DW-1:0] sq_data;
  logic stall_release, blocked_clear, mem_rsp_valid;
  logic rsp_valid, rsp_fwd, rsp_partial, rsp_mem_req, rsp_split, rsp_blocked, rsp_resched, rsp_fault;
  logic [2:0] rsp_lq_idx, rsp_src_idx, stall_lq_idx, load_done_idx;
  logic [DW-1:0] rsp_fwd_data;
  logic stall_active, blocked_active, load_done;
  logic [QW-1:0] stall_store_seq, blocked_seq;

  slf_lookup i_slf_lookup (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_seq(ld_seq), .ld_lq_idx(ld_lq_idx), .ld_sq_idx(ld_sq_idx), .ld_uncache(ld_uncache),
    .ld_at_commit(ld_at_commit), .ld_split(ld_split), .lq_head(lq_head),
    .cache_blocked(cache_blocked), .sq_wb_idx(sq_wb_idx), .sq_addr(sq_addr),
    .sq_size(sq_size), .sq_uncache(sq_uncache), .sq_seq(sq_seq), .sq_data(sq_data),
    .stall_release(stall_release), .blocked_clear(blocked_clear),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_lq_idx(mem_rsp_lq_idx),
    .rsp_valid(rsp_valid), .rsp_lq_idx(rsp_lq_idx), .rsp_fwd(rsp_fwd),
    .rsp_fwd_data(rsp_fwd_data), .rsp_src_idx(rsp_src_idx), .rsp_partial(rsp_partial),
    .rsp_mem_req(rsp_mem_req), .rsp_split(rsp_split), .rsp_blocked(rsp_blocked),
    .rsp_resched(rsp_resched), .rsp_fault(rsp_fault), .stall_active(stall_active),
    .stall_store_seq(stall_store_seq), .stall_lq_idx(stall_lq_idx),
    .blocked_active(blocked_active), .blocked_seq(blocked_seq),
    .load_done(load_done), .load_done_idx(load_done_idx)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string g_tag = "R11";

  // reference model state
  int m_st_act = 0, m_st_sseq = 0, m_st_lq = 0, m_st_lseq = 0;
  int m_bk_act = 0, m_bk_seq = 0;
  int m_cnt [LQ];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (scenario %s) %s: actual %0h expected %0h", req, g_tag, what, act, exp);
    end
  endtask

  task automatic tick();
    int kind, src, idx, found, slo, shi, llo, lhi, off, e_done, e_didx;
    logic [63:0] e_data;
    logic e_valid, e_split;
    kind = 0; src = 0; found = 0; e_data = '0; e_done = 0; e_didx = 0;
    e_valid = ld_valid; e_split = 1'b0;
    if (ld_valid) begin
      if (ld_uncache && !((ld_lq_idx == lq_head) && ld_at_commit)) kind = 5;
      else begin
        idx = int'(ld_sq_idx);
        while (idx != int'(sq_wb_idx) && found == 0) begin
          idx = (idx + D - 1) % D;
          if (sq_size[idx] != 0 && !sq_uncache[idx]) begin
            slo = int'(sq_addr[idx]); shi = slo + int'(sq_size[idx]);
            llo = int'(ld_addr);      lhi = llo + int'(ld_size);
            if (llo >= slo && lhi <= shi) begin
              kind = 1; src = idx; found = 1;
              off = llo & (int'(sq_size[idx]) - 1);
              for (int j = 0; j < DB; j++)
                if (j < int'(ld_size)) e_data[j*8 +: 8] = sq_data[idx][(off+j)*8 +: 8];
            end else if (llo < shi && lhi > slo) begin
              kind = 2; src = idx; found = 1;
            end
          end
        end
        if (found == 0) kind = cache_blocked ? 4 : 3;
      end
    end
    e_split = (kind == 3) && ld_split;
    // records
    if (stall_release) m_st_act = 0;
    if (kind == 2 && (m_st_act == 0 || int'(ld_seq) < m_st_lseq)) begin
      m_st_act = 1; m_st_sseq = int'(sq_seq[src]); m_st_lq = int'(ld_lq_idx); m_st_lseq = int'(ld_seq);
    end
    if (blocked_clear) m_bk_act = 0;
    if (kind == 4 && !(m_bk_act == 1 && m_bk_seq < int'(ld_seq))) begin
      m_bk_act = 1; m_bk_seq = int'(ld_seq);
    end
    if (mem_rsp_valid && m_cnt[mem_rsp_lq_idx] > 0) begin
      if (m_cnt[mem_rsp_lq_idx] == 1) begin e_done = 1; e_didx = int'(mem_rsp_lq_idx); end
      m_cnt[mem_rsp_lq_idx]--;
    end
    if (kind == 3) m_cnt[ld_lq_idx] = ld_split ? 2 : 1;

    @(posedge clk);
    @(negedge clk);
    chk("R12", "rsp_valid", 64'(rsp_valid), 64'(e_valid));
    chk("R4",  "rsp_fwd", 64'(rsp_fwd), 64'(kind == 1));
    chk("R4",  "rsp_fwd_data", rsp_fwd_data, e_data);
    chk("R5",  "rsp_partial", 64'(rsp_partial), 64'(kind == 2));
    chk("R5",  "rsp_resched", 64'(rsp_resched), 64'(kind == 2 || kind == 5));
    chk("R8",  "rsp_mem_req", 64'(rsp_mem_req), 64'(kind == 3));
    chk("R8",  "rsp_split", 64'(rsp_split), 64'(e_split));
    chk("R9",  "rsp_blocked", 64'(rsp_blocked), 64'(kind == 4));
    chk("R7",  "rsp_fault", 64'(rsp_fault), 64'(kind == 5));
    if (e_valid) chk("R12", "rsp_lq_idx", 64'(rsp_lq_idx), 64'(ld_lq_idx_q));
    if (kind == 1 || kind == 2) chk("R3", "rsp_src_idx", 64'(rsp_src_idx), 64'(src));
    chk("R6", "stall_active", 64'(stall_active), 64'(m_st_act));
    if (m_st_act != 0) begin
      chk("R6", "stall_store_seq", 64'(stall_store_seq), 64'(m_st_sseq));
      chk("R6", "stall_lq_idx", 64'(stall_lq_idx), 64'(m_st_lq));
    end
    chk("R9", "blocked_active", 64'(blocked_active), 64'(m_bk_act));
    if (m_bk_act != 0) chk("R9", "blocked_seq", 64'(blocked_seq), 64'(m_bk_seq));
    chk("R10", "load_done", 64'(load_done), 64'(e_done));
    if (e_done != 0) chk("R10", "load_done_idx", 64'(load_done_idx), 64'(e_didx));
  endtask

  // slot of the request just presented, captured for the lq index check
  logic [2:0] ld_lq_idx_q;
  always @(posedge clk) ld_lq_idx_q <= ld_lq_idx;

  task automatic idle_inputs();
    ld_valid = 0; ld_uncache = 0; ld_at_commit = 0; ld_split = 0; cache_blocked = 0;
    stall_release = 0; blocked_clear = 0; mem_rsp_valid = 0; mem_rsp_lq_idx = '0;
  endtask

  task automatic clear_sq();
    for (int e = 0; e < D; e++) begin
      sq_addr[e] = '0; sq_size[e] = '0; sq_uncache[e] = 0; sq_seq[e] = '0; sq_data[e] = '0;
    end
  endtask

  task automatic set_st(int e, int a, int s, bit uc, int q);
    sq_addr[e] = AW'(a); sq_size[e] = SW'(s); sq_uncache[e] = uc; sq_seq[e] = QW'(q);
    sq_data[e] = {$urandom, $urandom};
  endtask

  task automatic load(int a, int s, int sqi, int lqi, int q);
    idle_inputs();
    ld_valid = 1; ld_addr = AW'(a); ld_size = SW'(s); ld_sq_idx = 3'(sqi);
    ld_lq_idx = 3'(lqi); ld_seq = QW'(q);
  endtask

  function automatic int pick_size(int r);
    return (r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 4 : 8;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r;
    for (int i = 0; i < LQ; i++) m_cnt[i] = 0;
    rst_n = 0; idle_inputs(); clear_sq();
    ld_addr = '0; ld_size = SW'(1); ld_seq = '0; ld_lq_idx = '0; ld_sq_idx = '0;
    lq_head = '0; sq_wb_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R11", "stall_active in reset", 64'(stall_active), 64'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R11", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11", "stall_active", 64'(stall_active), 64'd0);
    chk("R11", "blocked_active", 64'(blocked_active), 64'd0);
    chk("R11", "load_done", 64'(load_done), 64'd0);

    // R4: full containment with byte offset
    g_tag = "R4";
    set_st(0, 'h10, 8, 0, 1);
    load('h14, 4, 1, 0, 10); tick();
    load('h10, 1, 1, 1, 11); tick();
    load('h16, 2, 1, 1, 11); tick();

    // R3: youngest of several containing stores
    g_tag = "R3";
    set_st(1, 'h10, 4, 0, 2);
    set_st(2, 'h10, 8, 0, 3);
    load('h10, 2, 3, 2, 12); tick();
    load('h12, 2, 2, 2, 12); tick();
    set_st(3, 'h14, 4, 0, 4);
    load('h12, 4, 4, 2, 12); tick();

    // R5/R6: partial overlap and the stall record
    g_tag = "R6";
    clear_sq(); set_st(0, 'h20, 4, 0, 7);
    load('h22, 4, 1, 3, 50); tick();
    load('h1e, 4, 1, 4, 60); tick();
    load('h22, 8, 1, 5, 40); tick();
    idle_inputs(); stall_release = 1; tick();
    idle_inputs(); stall_release = 1; tick();
    load('h22, 4, 1, 6, 90); stall_release = 1; tick();
    idle_inputs(); stall_release = 1; tick();

    // R1: window bounds and wrap
    g_tag = "R1";
    clear_sq(); sq_wb_idx = 3'd5;
    set_st(6, 'h40, 8, 0, 20);
    set_st(3, 'h40, 4, 0, 21);
    set_st(2, 'h40, 8, 0, 22);
    load('h40, 4, 1, 0, 30); tick();
    load('h40, 4, 5, 0, 30); tick();
    load('h40, 4, 4, 0, 30); tick();
    sq_wb_idx = 3'd0;

    // R2: unknown-size and uncacheable stores skipped
    g_tag = "R2";
    clear_sq();
    set_st(0, 'h50, 8, 0, 5);
    set_st(1, 'h50, 0, 0, 6);
    set_st(2, 'h50, 8, 1, 7);
    load('h50, 4, 3, 1, 33); tick();
    clear_sq(); set_st(1, 'h50, 0, 0, 6); set_st(2, 'h50, 8, 1, 7);
    load('h50, 4, 3, 1, 34); tick();

    // R9: cache blocked record
    g_tag = "R9";
    clear_sq();
    load('h60, 4, 0, 1, 30); cache_blocked = 1; tick();
    load('h60, 4, 0, 2, 35); cache_blocked = 1; tick();
    load('h60, 4, 0, 3, 20); cache_blocked = 1; tick();
    idle_inputs(); blocked_clear = 1; tick();
    load('h60, 4, 0, 3, 45); cache_blocked = 1; blocked_clear = 1; tick();
    idle_inputs(); blocked_clear = 1; tick();

    // R7: uncacheable load gating
    g_tag = "R7";
    lq_head = 3'd0;
    load('h70, 4, 0, 2, 9); ld_uncache = 1; ld_at_commit = 1; tick();
    load('h70, 4, 0, 0, 9); ld_uncache = 1; ld_at_commit = 0; tick();
    load('h70, 4, 0, 0, 9); ld_uncache = 1; ld_at_commit = 1; tick();

    // R10: split completion
    g_tag = "R10";
    load('h80, 8, 0, 3, 1); ld_split = 1; tick();
    load('h88, 4, 0, 4, 2); tick();
    idle_inputs(); mem_rsp_valid = 1; mem_rsp_lq_idx = 3'd3; tick();
    idle_inputs(); mem_rsp_valid = 1; mem_rsp_lq_idx = 3'd4; tick();
    idle_inputs(); mem_rsp_valid = 1; mem_rsp_lq_idx = 3'd3; tick();
    idle_inputs(); tick();

    // R12: broad mixed traffic
    g_tag = "R12";
    for (int n = 0; n < 4000; n++) begin
      if (n % 40 == 0) begin
        for (int e = 0; e < D; e++) begin
          r = $urandom_range(0, 4);
          if (r == 4) set_st(e, 0, 0, 0, $urandom_range(0, 255));
          else begin
            set_st(e, $urandom_range(0, 63) & ~(pick_size(r) - 1), pick_size(r),
                   ($urandom_range(0, 7) == 0), $urandom_range(0, 255));
          end
        end
        sq_wb_idx = 3'($urandom_range(0, 7));
      end
      idle_inputs();
      ld_valid      = ($urandom_range(0, 3) != 0);
      ld_addr       = AW'($urandom_range(0, 63));
      ld_size       = SW'(pick_size($urandom_range(0, 3)));
      ld_sq_idx     = 3'($urandom_range(0, 7));
      ld_lq_idx     = 3'($urandom_range(0, 7));
      ld_seq        = QW'($urandom_range(0, 255));
      ld_uncache    = ($urandom_range(0, 7) == 0);
      ld_at_commit  = $urandom_range(0, 1) != 0;
      lq_head       = 3'($urandom_range(0, 7));
      ld_split      = $urandom_range(0, 1) != 0;
      cache_blocked = ($urandom_range(0, 4) == 0);
      stall_release = ($urandom_range(0, 9) == 0);
      blocked_clear = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 1) != 0) begin
        r = $urandom_range(0, 7);
        for (int k = 0; k < LQ; k++) begin
          if (!mem_rsp_valid && m_cnt[(r + k) % LQ] > 0 &&
              !(ld_valid && ((r + k) % LQ) == int'(ld_lq_idx))) begin
            mem_rsp_valid = 1; mem_rsp_lq_idx = 3'((r + k) % LQ);
          end
        end
      end
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule